// File: doc/BRIEF.md
# Half-Bridge Submodule Valve Stepper

This block advances a fixed-point model of one converter valve, built from a stack of half-bridge submodules, by one simulation step each time it is triggered. A network solver outside the block supplies the valve current. The two gate bits of every submodule are captured with it. For each submodule the block works out an operating mode from its gate pair. It then forms two diode-steered equivalent source voltages and advances that submodule's capacitor voltage. The per-submodule sources are added into two valve-level totals, which go back to the solver. All capacitor voltages and a sticky shoot-through flag per submodule are also exposed.

The submodules are handled one after another through a single three-stage pipeline. All quantities are signed Q16.16. Each submodule has its own step-scaled inverse-capacitance coefficient (dt/C) held in an inferred RAM. A shared discharge conductance coefficient (1/R) applies to every submodule. Every add and multiply saturates to the 32-bit signed range instead of wrapping.

Top module: `hbv_valve_engine`

## Requirements
- R1: A synchronous reset loads every capacitor voltage from `vc_init`, clears all fault flags and both totals, and holds `step_done` low.
- R2: Gate pair (upper,lower) = (1,0) selects insert: the positive source is Vc + v_diode, the negative source is Vc - v_switch, and the charging selector k is 1 for either current sign.
- R3: Gate pair (0,1) selects bypass: the positive source is v_switch, the negative source is -v_diode, and k is 0, so Vc changes only by discharge.
- R4: Gate pair (0,0) selects the blocked diode mode: the positive source is Vc + v_diode and the negative source is -v_diode. k is 1 when the valve current is positive and 0 when it is negative.
- R5: Gate pair (1,1) selects shoot-through: the sources are +v_switch and -v_switch, the capacitor voltage is held exactly (no discharge), and that submodule's fault flag is set. The flag stays set until reset.
- R6: The capacitor update is Vc' = Vc + g_i*(k*i_valve - Vc*leak_coef). Each product is the full signed product shifted right arithmetically by 16 and saturated. The subtraction and the final add also saturate.
- R7: The totals are the saturating sums of the per-submodule sources, added in submodule index order 0..N_SM-1. A sum that passes 0x7FFFFFFF or -0x80000000 clamps there.
- R8: `step_done` is a single-cycle pulse on the (N_SM+2)-th rising edge after the edge that accepts `step_start`. At that pulse the totals, all capacitor voltages and the flags reflect the completed step.
- R9: `step_start` is ignored while a step is in progress. Outside a step, capacitor voltages and flags do not change.
- R10: Writing `coef_data` at `coef_addr` with `coef_we` sets submodule `coef_addr`'s dt/C coefficient. Each submodule uses its own coefficient.
- R11: The sources of a step use each submodule's capacitor voltage from the start of that step. Gates, current, drops and leak coefficient are captured when the step is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_init | input | 32 | Capacitor voltage loaded at reset, Q16.16 |
| v_diode | input | 32 | Diode forward drop, Q16.16 |
| v_switch | input | 32 | Switch forward drop, Q16.16 |
| leak_coef | input | 32 | Discharge conductance coefficient 1/R, Q16.16 |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | $clog2(N_SM) | Submodule index for the coefficient write |
| coef_data | input | 32 | dt/C coefficient, Q16.16 |
| step_start | input | 1 | Begin one simulation step |
| gate_upper | input | N_SM | Upper gate bit per submodule |
| gate_lower | input | N_SM | Lower gate bit per submodule |
| i_valve | input | 32 | Valve current from the solver, Q16.16 |
| vsp_total | output | 32 | Sum of positive-direction sources |
| vsn_total | output | 32 | Sum of negative-direction sources |
| vc_all | output | N_SM*32 | All capacitor voltages, submodule j at bits j*32 upward |
| fault_flags | output | N_SM | Sticky shoot-through flag per submodule |
| step_done | output | 1 | One-cycle pulse at step completion |

## Verification
The bench drives mixed gate patterns in which every mode appears at once. It runs them with positive and then negative valve current, so a design that steers the diode-mode charging selector by gate state alone is caught through the capacitor voltages. A shoot-through submodule that later returns to diode mode must keep its flag and must not have decayed during the fault step. A design that applied discharge in that mode, or cleared the flag, would show a wrong voltage or flag. Stacks of large positive and negative initial voltages drive both totals past the 32-bit limits, so a wrapping accumulator shows the wrong sign. A start request held for several cycles must yield one step only; a design that restarts would give an extra done pulse and doubled voltage changes.

// File: rtl/hbv_pkg.sv
package hbv_pkg;
  localparam int QW   = 32;
  localparam int FRAC = 16;

  typedef enum logic [1:0] {
    SM_INSERT  = 2'd0,
    SM_BYPASS  = 2'd1,
    SM_BLOCKED = 2'd2,
    SM_SHORT   = 2'd3
  } sm_mode_e;

  localparam logic signed [QW-1:0] Q_MAX = {1'b0, {(QW-1){1'b1}}};
  localparam logic signed [QW-1:0] Q_MIN = {1'b1, {(QW-1){1'b0}}};

  function automatic logic signed [QW-1:0] sat_add(input logic signed [QW-1:0] a,
                                                   input logic signed [QW-1:0] b);
    logic [QW:0] s;
    s = {a[QW-1], a} + {b[QW-1], b};
    if (s[QW] != s[QW-1]) return s[QW] ? Q_MIN : Q_MAX;
    return s[QW-1:0];
  endfunction

  function automatic logic signed [QW-1:0] sat_sub(input logic signed [QW-1:0] a,
                                                   input logic signed [QW-1:0] b);
    logic [QW:0] s;
    s = {a[QW-1], a} - {b[QW-1], b};
    if (s[QW] != s[QW-1]) return s[QW] ? Q_MIN : Q_MAX;
    return s[QW-1:0];
  endfunction

  function automatic logic signed [QW-1:0] q_mul(input logic signed [QW-1:0] a,
                                                 input logic signed [QW-1:0] b);
    logic signed [2*QW-1:0] p;
    logic signed [2*QW-1:0] sh;
    p  = a * b;
    sh = p >>> FRAC;
    if (!(&sh[2*QW-1:QW-1]) && (|sh[2*QW-1:QW-1]))
      return sh[2*QW-1] ? Q_MIN : Q_MAX;
    return sh[QW-1:0];
  endfunction
endpackage

// File: rtl/hbv_coef_ram.sv
module hbv_coef_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hbv_mode_eval.sv
module hbv_mode_eval
  import hbv_pkg::*;
(
  input  logic                 g_up,
  input  logic                 g_lo,
  input  logic signed [QW-1:0] vc,
  input  logic signed [QW-1:0] i_valve,
  input  logic signed [QW-1:0] v_dio,
  input  logic signed [QW-1:0] v_sw,
  output logic signed [QW-1:0] vsp,
  output logic signed [QW-1:0] vsn,
  output logic                 charge_en,
  output logic                 hold
);
  sm_mode_e mode;
  logic signed [QW-1:0] zero;

  assign zero = '0;

  always_comb begin
    unique case ({g_up, g_lo})
      2'b10:   mode = SM_INSERT;
      2'b01:   mode = SM_BYPASS;
      2'b00:   mode = SM_BLOCKED;
      default: mode = SM_SHORT;
    endcase
  end

  always_comb begin
    vsp       = '0;
    vsn       = '0;
    charge_en = 1'b0;
    hold      = 1'b0;
    unique case (mode)
      SM_INSERT: begin
        vsp       = sat_add(vc, v_dio);
        vsn       = sat_sub(vc, v_sw);
        charge_en = 1'b1;
      end
      SM_BYPASS: begin
        vsp = v_sw;
        vsn = sat_sub(zero, v_dio);
      end
      SM_BLOCKED: begin
        vsp       = sat_add(vc, v_dio);
        vsn       = sat_sub(zero, v_dio);
        charge_en = (i_valve > zero);
      end
      SM_SHORT: begin
        vsp  = v_sw;
        vsn  = sat_sub(zero, v_sw);
        hold = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hbv_cap_step.sv
module hbv_cap_step
  import hbv_pkg::*;
(
  input  logic signed [QW-1:0] vc,
  input  logic signed [QW-1:0] coef,
  input  logic signed [QW-1:0] leak,
  input  logic signed [QW-1:0] i_valve,
  input  logic                 charge_en,
  input  logic                 hold,
  output logic signed [QW-1:0] vc_next
);
  logic signed [QW-1:0] term;
  logic signed [QW-1:0] drain;
  logic signed [QW-1:0] net;
  logic signed [QW-1:0] delta;

  always_comb begin
    term    = charge_en ? i_valve : '0;
    drain   = q_mul(vc, leak);
    net     = sat_sub(term, drain);
    delta   = q_mul(coef, net);
    vc_next = hold ? vc : sat_add(vc, delta);
  end
endmodule

// File: rtl/hbv_sat_acc.sv
module hbv_sat_acc
  import hbv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [QW-1:0] addend,
  output logic signed [QW-1:0] sum_q,
  output logic signed [QW-1:0] sum_nx
);
  assign sum_nx = sat_add(sum_q, addend);

  always_ff @(posedge clk) begin
    if (rst || clr) sum_q <= '0;
    else if (en)    sum_q <= sum_nx;
  end
endmodule

// File: rtl/hbv_valve_engine.sv
module hbv_valve_engine
  import hbv_pkg::*;
#(
  parameter int N_SM = 8,
  localparam int IDXW = (N_SM > 1) ? $clog2(N_SM) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [QW-1:0]   vc_init,
  input  logic signed [QW-1:0]   v_diode,
  input  logic signed [QW-1:0]   v_switch,
  input  logic signed [QW-1:0]   leak_coef,
  input  logic                   coef_we,
  input  logic [IDXW-1:0]        coef_addr,
  input  logic [QW-1:0]          coef_data,
  input  logic                   step_start,
  input  logic [N_SM-1:0]        gate_upper,
  input  logic [N_SM-1:0]        gate_lower,
  input  logic signed [QW-1:0]   i_valve,
  output logic signed [QW-1:0]   vsp_total,
  output logic signed [QW-1:0]   vsn_total,
  output logic [N_SM*QW-1:0]     vc_all,
  output logic [N_SM-1:0]        fault_flags,
  output logic                   step_done
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N_SM - 1);

  // sequencer and step snapshot
  logic                 busy, issuing, accept;
  logic [IDXW-1:0]      idx_q;
  logic [N_SM-1:0]      gu_q, gl_q;
  logic signed [QW-1:0] iv_q, vd_q, vs_q, lk_q;

  // per-submodule state
  logic signed [QW-1:0] vc_q [N_SM];
  logic [N_SM-1:0]      flag_q;

  // stage 1
  logic                 s1_v;
  logic [IDXW-1:0]      s1_idx;
  logic                 s1_gu, s1_gl;
  logic signed [QW-1:0] s1_vc;
  logic [QW-1:0]        coef_q;
  logic signed [QW-1:0] vsp_c, vsn_c, vcn_c;
  logic                 chg_c, hold_c;

  // stage 2
  logic                 s2_v, s2_last, s2_fault;
  logic [IDXW-1:0]      s2_idx;
  logic signed [QW-1:0] s2_vcn, s2_vsp, s2_vsn;

  logic signed [QW-1:0] acc_sp_q, acc_sp_nx, acc_sn_q, acc_sn_nx;

  assign accept = step_start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      idx_q   <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      issuing <= 1'b1;
      idx_q   <= '0;
    end else begin
      if (issuing) begin
        if (idx_q == LAST_IDX) issuing <= 1'b0;
        else                   idx_q   <= idx_q + 1'b1;
      end
      if (s2_v && s2_last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gu_q <= '0;
      gl_q <= '0;
      iv_q <= '0;
      vd_q <= '0;
      vs_q <= '0;
      lk_q <= '0;
    end else if (accept) begin
      gu_q <= gate_upper;
      gl_q <= gate_lower;
      iv_q <= i_valve;
      vd_q <= v_diode;
      vs_q <= v_switch;
      lk_q <= leak_coef;
    end
  end

  hbv_coef_ram #(.DEPTH(N_SM), .W(QW), .AW(IDXW)) coef_ram_i (
    .clk   (clk),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_data),
    .raddr (idx_q),
    .rdata (coef_q)
  );

  // stage 1 register: fetch state of the issued submodule
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_idx <= '0;
      s1_gu  <= 1'b0;
      s1_gl  <= 1'b0;
      s1_vc  <= '0;
    end else begin
      s1_v   <= issuing;
      s1_idx <= idx_q;
      s1_gu  <= gu_q[idx_q];
      s1_gl  <= gl_q[idx_q];
      s1_vc  <= vc_q[idx_q];
    end
  end

  hbv_mode_eval mode_i (
    .g_up      (s1_gu),
    .g_lo      (s1_gl),
    .vc        (s1_vc),
    .i_valve   (iv_q),
    .v_dio     (vd_q),
    .v_sw      (vs_q),
    .vsp       (vsp_c),
    .vsn       (vsn_c),
    .charge_en (chg_c),
    .hold      (hold_c)
  );

  hbv_cap_step cap_i (
    .vc        (s1_vc),
    .coef      (coef_q),
    .leak      (lk_q),
    .i_valve   (iv_q),
    .charge_en (chg_c),
    .hold      (hold_c),
    .vc_next   (vcn_c)
  );

  // stage 2 register: per-submodule results
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v     <= 1'b0;
      s2_last  <= 1'b0;
      s2_fault <= 1'b0;
      s2_idx   <= '0;
      s2_vcn   <= '0;
      s2_vsp   <= '0;
      s2_vsn   <= '0;
    end else begin
      s2_v     <= s1_v;
      s2_last  <= s1_v && (s1_idx == LAST_IDX);
      s2_fault <= hold_c;
      s2_idx   <= s1_idx;
      s2_vcn   <= vcn_c;
      s2_vsp   <= vsp_c;
      s2_vsn   <= vsn_c;
    end
  end

  // writeback
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N_SM; j++) vc_q[j] <= vc_init;
    end else if (s2_v) begin
      vc_q[s2_idx] <= s2_vcn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   flag_q         <= '0;
    else if (s2_v && s2_fault) flag_q[s2_idx] <= 1'b1;
  end

  hbv_sat_acc acc_sp_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .en     (s2_v),
    .addend (s2_vsp),
    .sum_q  (acc_sp_q),
    .sum_nx (acc_sp_nx)
  );

  hbv_sat_acc acc_sn_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .en     (s2_v),
    .addend (s2_vsn),
    .sum_q  (acc_sn_q),
    .sum_nx (acc_sn_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vsp_total <= '0;
      vsn_total <= '0;
      step_done <= 1'b0;
    end else begin
      step_done <= s2_v && s2_last;
      if (s2_v && s2_last) begin
        vsp_total <= acc_sp_nx;
        vsn_total <= acc_sn_nx;
      end
    end
  end

  generate
    for (genvar g = 0; g < N_SM; g++) begin : g_vc_out
      assign vc_all[g*QW +: QW] = vc_q[g];
    end
  endgenerate

  assign fault_flags = flag_q;
endmodule

// File: rtl/hbv_valve_chk.sv
module hbv_valve_chk #(
  parameter int N_SM = 8,
  parameter int QW   = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 step_start,
  input logic                 step_done,
  input logic [N_SM*QW-1:0]   vc_all,
  input logic [N_SM-1:0]      fault_flags
);
  localparam int CW = $clog2(N_SM + 4) + 1;

  logic          act;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (!act && step_start) begin
      act <= 1'b1;
      cnt <= '0;
    end else if (act) begin
      cnt <= cnt + 1'b1;
      if (step_done) act <= 1'b0;
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    step_done |-> (act && cnt == CW'(N_SM + 2))); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_done); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((fault_flags & $past(fault_flags)) == $past(fault_flags))); // R5

  AST_VC_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!act && $past(!act)) |-> $stable(vc_all)); // R9

  AST_FLAGS_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!act && $past(!act)) |-> $stable(fault_flags)); // R9
endmodule

bind hbv_valve_engine hbv_valve_chk #(.N_SM(N_SM), .QW(hbv_pkg::QW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .step_start  (step_start),
  .step_done   (step_done),
  .vc_all      (vc_all),
  .fault_flags (fault_flags)
);

// File: tb/hbv_valve_engine_tb_top.sv
module hbv_valve_engine_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst = 1'b1;
  logic signed [31:0]   vc_init = '0, v_diode = '0, v_switch = '0, leak_coef = '0;
  logic                 coef_we = 1'b0;
  logic [IW-1:0]        coef_addr = '0;
  logic [31:0]          coef_data = '0;
  logic                 step_start = 1'b0;
  logic [N-1:0]         gate_upper = '0, gate_lower = '0;
  logic signed [31:0]   i_valve = '0;
  logic signed [31:0]   vsp_total, vsn_total;
  logic [N*32-1:0]      vc_all;
  logic [N-1:0]         fault_flags;
  logic                 step_done;

  hbv_valve_engine #(.N_SM(N)) dut_i (
    .clk(clk), .rst(rst), .vc_init(vc_init), .v_diode(v_diode), .v_switch(v_switch),
    .leak_coef(leak_coef), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .step_start(step_start), .gate_upper(gate_upper), .gate_lower(gate_lower),
    .i_valve(i_valve), .vsp_total(vsp_total), .vsn_total(vsn_total), .vc_all(vc_all),
    .fault_flags(fault_flags), .step_done(step_done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, dones = 0, exp_dones = 0;

  typedef struct {
    logic signed [31:0] sp;
    logic signed [31:0] sn;
    logic [N*32-1:0]    vc;
    logic [N-1:0]       fl;
    int                 c0;
    string              tag;
  } exp_t;
  exp_t sbq[$];

  // model state
  logic signed [31:0] mvc [N];
  logic signed [31:0] mcoef [N];
  logic [N-1:0]       mfl;

  function automatic logic signed [31:0] bsat(input logic signed [63:0] x);
    if (x > 64'sd2147483647)  return 32'sh7FFFFFFF;
    if (x < -64'sd2147483648) return 32'sh80000000;
    return x[31:0];
  endfunction
  function automatic logic signed [31:0] badd(input logic signed [31:0] a, input logic signed [31:0] b);
    return bsat(longint'(a) + longint'(b));
  endfunction
  function automatic logic signed [31:0] bsub(input logic signed [31:0] a, input logic signed [31:0] b);
    return bsat(longint'(a) - longint'(b));
  endfunction
  function automatic logic signed [31:0] bmul(input logic signed [31:0] a, input logic signed [31:0] b);
    return bsat((longint'(a) * longint'(b)) >>> 16);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  // monitor: pops expected items at each completion
  always @(negedge clk) begin
    if (!rst && step_done) begin
      dones++;
      if (sbq.size() == 0) begin
        check(1'b0, "R9", "unexpected step_done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(cyc == e.c0 + N + 3, "R8", {e.tag, " done latency"}, 64'(cyc - e.c0), 64'(N + 3));
        check(vsp_total == e.sp, "R7", {e.tag, " vsp_total"}, 64'(vsp_total), 64'(e.sp));
        check(vsn_total == e.sn, "R7", {e.tag, " vsn_total"}, 64'(vsn_total), 64'(e.sn));
        for (int j = 0; j < N; j++)
          check(vc_all[j*32 +: 32] == e.vc[j*32 +: 32], "R6", {e.tag, $sformatf(" vc[%0d]", j)},
                64'(vc_all[j*32 +: 32]), 64'(e.vc[j*32 +: 32]));
        check(fault_flags == e.fl, "R5", {e.tag, " fault_flags"}, 64'(fault_flags), 64'(e.fl));
      end
    end
  end

  task automatic do_reset(input logic signed [31:0] init);
    @(negedge clk);
    vc_init = init;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < N; j++) mvc[j] = init;
    mfl = '0;
    @(negedge clk);
    for (int j = 0; j < N; j++)
      check(vc_all[j*32 +: 32] == init, "R1", $sformatf("reset vc[%0d]", j),
            64'(vc_all[j*32 +: 32]), 64'(init));
    check(fault_flags == '0, "R1", "reset flags", 64'(fault_flags), 64'd0);
    check(vsp_total == 0 && vsn_total == 0, "R1", "reset totals", {vsp_total, vsn_total}, 64'd0);
    check(step_done == 1'b0, "R1", "reset step_done", 64'(step_done), 64'd0);
  endtask

  task automatic load_coefs();
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      coef_we = 1'b1;
      coef_addr = IW'(j);
      coef_data = mcoef[j];
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // driver: computes expected result, pushes it, starts the step
  task automatic run_step(input logic [N-1:0] gu, input logic [N-1:0] gl,
                          input logic signed [31:0] iv, input string tag, input int hold_cyc);
    exp_t e;
    logic signed [31:0] sp, sn, vc, vcn;
    logic signed [31:0] accp, accn;
    logic k, hold;
    accp = 0;
    accn = 0;
    for (int j = 0; j < N; j++) begin
      vc = mvc[j];
      k = 1'b0;
      hold = 1'b0;
      case ({gu[j], gl[j]})
        2'b10: begin sp = badd(vc, v_diode); sn = bsub(vc, v_switch); k = 1'b1; end
        2'b01: begin sp = v_switch; sn = bsub(0, v_diode); end
        2'b00: begin sp = badd(vc, v_diode); sn = bsub(0, v_diode); k = (iv > 0); end
        default: begin sp = v_switch; sn = bsub(0, v_switch); hold = 1'b1; mfl[j] = 1'b1; end
      endcase
      vcn = hold ? vc : badd(vc, bmul(mcoef[j], bsub(k ? iv : 32'sd0, bmul(vc, leak_coef))));
      accp = badd(accp, sp);
      accn = badd(accn, sn);
      e.vc[j*32 +: 32] = vcn;
    end
    for (int j = 0; j < N; j++) mvc[j] = e.vc[j*32 +: 32];
    e.sp = accp;
    e.sn = accn;
    e.fl = mfl;
    e.tag = tag;
    @(negedge clk);
    gate_upper = gu;
    gate_lower = gl;
    i_valve = iv;
    step_start = 1'b1;
    e.c0 = cyc;
    sbq.push_back(e);
    exp_dones++;
    repeat (hold_cyc) @(negedge clk);
    step_start = 1'b0;
    while (sbq.size() > 0) @(negedge clk);
  endtask

  initial begin
    v_diode   = 32'sh0000_8000;
    v_switch  = 32'sh0000_4000;
    leak_coef = 32'sh0000_0400;
    for (int j = 0; j < N; j++) mcoef[j] = 32'sh0000_1000 * (j + 1);
    do_reset(32'sh0010_0000);
    load_coefs();

    // R2 R10: all inserted, positive current, distinct coefficients
    run_step(8'hFF, 8'h00, 32'sh0002_0000, "R2 R10 insert", 1);
    // R3 R4 R5 R11: every mode in one step, positive current
    run_step(8'b0100_1001, 8'b0010_1010, 32'sh0001_8000, "R3 R4 R5 R11 mixed+", 1);
    // R4: negative current, diode submodules must not charge
    run_step(8'b0100_1001, 8'b0010_1010, -32'sh0003_0000, "R4 mixed-", 1);
    // R5: former shoot-through submodule now blocked, flag stays
    run_step(8'h00, 8'h00, -32'sh0001_0000, "R5 sticky", 1);
    // R9: start held across busy cycles gives one step
    run_step(8'h0F, 8'hF0, 32'sh0000_C000, "R9 held start", 3);
    repeat (20) @(negedge clk);
    check(dones == exp_dones, "R9", "done count", 64'(dones), 64'(exp_dones));
    for (int j = 0; j < N; j++)
      check(vc_all[j*32 +: 32] == mvc[j], "R9", $sformatf("idle vc[%0d]", j),
            64'(vc_all[j*32 +: 32]), 64'(mvc[j]));

    // R7: saturation of both totals, upward then downward
    leak_coef = '0;
    do_reset(32'sh7000_0000);
    run_step(8'hFF, 8'h00, 32'sh0, "R7 sat high", 1);
    do_reset(32'sh9000_0000);
    run_step(8'hFF, 8'h00, 32'sh0, "R7 sat low", 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule